// File: doc/BRIEF.md
# Dual-Unit Snoop Stream Router

This block sits in the data path of one processing channel. It lets a single pass over a payload feed two execution units. The primary unit, a cipher, takes its words from memory through the controller. The secondary unit is always the hash unit, and it never fetches data of its own. It gets its words by tapping an internal stream, and a two-bit mode selects the tap point.

In input-tap mode, the hash unit receives the same words that enter the cipher. In output-tap mode, it receives the words the cipher produces, and those words still go on to the output path. A tapped word moves only when both of its consumers can take it in the same cycle, so neither unit drops a word or sees one twice. The end-of-packet flag travels with every word and is copied to the hash stream.

The mode can change only while no packet is in flight. A mode write that arrives during a packet is discarded and sets a sticky error flag.

Top module: `snoop_router`

## Requirements
- R1: After reset, `cur_mode` is 00, `cfg_err` is 0 and `sec_valid` is 0.
- R2: In mode 00, and in the reserved mode 11, memory words pass straight to the primary input and primary output words pass straight to the output path. `sec_valid` stays 0.
- R3: In mode 01 (input tap), every word accepted from memory is delivered once to the primary input and once to the secondary stream, in order and with the same data.
- R4: In mode 01, a memory word transfers only in a cycle where `pin_ready` and `sec_ready` are both high, and the primary and secondary transfers happen in that same cycle.
- R5: In mode 10 (output tap), every primary output word is delivered once to the output path and once to the secondary stream, in order and with the same data.
- R6: In mode 10, `pout_ready` is low whenever `sec_ready` or `out_ready` is low, and the output-path and secondary transfers happen in the same cycle.
- R7: The end-of-packet flag of each tapped word appears on `sec_last` together with that word.
- R8: A write (`cfg_valid` high) made while idle stores `cfg_mode`. The stored value appears on `cur_mode` from the next cycle, and routing uses it from that cycle.
- R9: A write made while a packet is in flight leaves `cur_mode` unchanged and sets `cfg_err`. `cfg_err` stays set until reset.
- R10: A packet is in flight from its first accepted memory word until the primary output accepts its end-of-packet word. This includes the span after input has finished but before the output has finished.
- R11: In any cycle with `cfg_valid` high, no stream transfers: `mem_ready`, `pout_ready`, `pin_valid`, `out_valid` and `sec_valid` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_valid | input | 1 | Mode write strobe |
| cfg_mode | input | 2 | Mode to write: 00 none, 01 input tap, 10 output tap, 11 reserved (acts as none) |
| cur_mode | output | 2 | Stored mode |
| cfg_err | output | 1 | Sticky flag: a write was made while busy |
| mem_valid | input | 1 | Memory-side word valid |
| mem_data | input | DATA_W | Memory-side word |
| mem_last | input | 1 | Memory-side end of packet |
| mem_ready | output | 1 | Memory-side word accepted |
| pin_valid | output | 1 | Primary input word valid |
| pin_data | output | DATA_W | Primary input word |
| pin_last | output | 1 | Primary input end of packet |
| pin_ready | input | 1 | Primary unit can take a word |
| pout_valid | input | 1 | Primary output word valid |
| pout_data | input | DATA_W | Primary output word |
| pout_last | input | 1 | Primary output end of packet |
| pout_ready | output | 1 | Primary output word accepted |
| out_valid | output | 1 | Output-path word valid |
| out_data | output | DATA_W | Output-path word |
| out_last | output | 1 | Output-path end of packet |
| out_ready | input | 1 | Output path can take a word |
| sec_valid | output | 1 | Secondary (hash) word valid |
| sec_data | output | DATA_W | Secondary word |
| sec_last | output | 1 | Secondary end of packet |
| sec_ready | input | 1 | Secondary unit can take a word |

## Verification
A mode write can land in the same cycle that a stream word is offered. The bench provokes this in two ways. First, it raises `cfg_valid` while the idle router has a memory word waiting; the expectation is that every stream is stalled for that cycle and that the word then moves under the new mode. Second, it writes while the cipher still holds output for a packet whose input has already finished; the expectation is that the write is refused and the error flag is set. A behavioural model of the mode, the busy state and per-stream word queues is compared with the ports on every clock.

// File: rtl/snoop_router_pkg.sv
// Package: shared mode encoding for the snoop stream router.
// Assumes: two-bit mode field written by the channel configuration.
package snoop_router_pkg;

    typedef enum logic [1:0] {
        SNOOP_NONE = 2'b00,
        SNOOP_IN   = 2'b01,
        SNOOP_OUT  = 2'b10,
        SNOOP_RSVD = 2'b11
    } snoop_mode_e;

endpackage

// File: rtl/snoop_fork.sv
// Module: snoop_fork
// Copies one valid/ready stream to a main consumer A and, when tap_en is
// high, also to a tap consumer B. A word moves only when every enabled
// consumer is ready, so both see it in the same cycle. hold stalls all.
// Assumes: consumer ready signals do not depend combinationally on valid.
module snoop_fork #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tap_en,
    input  logic              hold,
    input  logic              s_valid,
    input  logic [DATA_W-1:0] s_data,
    input  logic              s_last,
    output logic              s_ready,
    output logic              a_valid,
    output logic [DATA_W-1:0] a_data,
    output logic              a_last,
    input  logic              a_ready,
    output logic              b_valid,
    output logic [DATA_W-1:0] b_data,
    output logic              b_last,
    input  logic              b_ready
);

    logic b_ok;

    // Purpose: the tap only gates progress when it is enabled.
    always_comb b_ok = b_ready || !tap_en;

    // Purpose: cross-gate the valids so a single source word moves to all consumers together.
    always_comb begin
        s_ready = !hold && a_ready && b_ok;
        a_valid = s_valid && !hold && b_ok;
        b_valid = s_valid && !hold && tap_en && a_ready;
        a_data  = s_data;
        a_last  = s_last;
        b_data  = s_data;
        b_last  = s_last;
    end

    // A source transfer always means the main consumer took the word (R4, R6).
    assert_src_hits_main_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_ready) |-> (a_valid && a_ready));

    // With the tap on, the tap consumer takes the same word in the same cycle (R6).
    assert_src_hits_tap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tap_en && s_valid && s_ready) |-> (b_valid && b_ready));

endmodule

// File: rtl/snoop_track.sv
// Module: snoop_track
// Tracks whether a packet is in flight: an input packet is open, an output
// packet is open, or input packets have ended whose output has not.
// Assumes: the primary unit never closes an output packet before its input.
module snoop_track #(
    parameter int PEND_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_fire,
    input  logic in_last,
    input  logic out_fire,
    input  logic out_last,
    output logic idle
);

    localparam logic [PEND_W-1:0] PEND_MAX = {PEND_W{1'b1}};

    logic              in_open_q;
    logic              out_open_q;
    logic [PEND_W-1:0] pend_q;
    logic              pend_inc;
    logic              pend_dec;

    // Purpose: decode packet-closing transfers on each side.
    always_comb begin
        pend_inc = in_fire && in_last;
        pend_dec = out_fire && out_last;
    end

    // Purpose: update the open-packet flags and the pending packet count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_open_q  <= 1'b0;
            out_open_q <= 1'b0;
            pend_q     <= '0;
        end else begin
            if (in_fire)  in_open_q  <= !in_last;
            if (out_fire) out_open_q <= !out_last;
            case ({pend_inc, pend_dec})
                2'b10:   pend_q <= pend_q + 1'b1;
                2'b01:   pend_q <= pend_q - 1'b1;
                default: pend_q <= pend_q;
            endcase
        end
    end

    // Purpose: idle only when no packet is open and none is pending.
    always_comb idle = !in_open_q && !out_open_q && (pend_q == '0);

    // The pending count never wraps upward (R10).
    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(pend_q == PEND_MAX && pend_inc && !pend_dec));

    // The pending count never wraps downward (R10).
    assert_no_underflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(pend_q == '0 && pend_dec && !pend_inc));

endmodule

// File: rtl/snoop_mode_ctrl.sv
// Module: snoop_mode_ctrl
// Holds the routing mode. A write is taken only while idle; a write made
// while busy is dropped and sets a sticky error flag.
// Assumes: idle comes from registered tracking state only.
module snoop_mode_ctrl
    import snoop_router_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_valid,
    input  logic [1:0]  cfg_mode,
    input  logic        idle,
    output snoop_mode_e mode_q,
    output logic        err_q
);

    // Purpose: store the mode on an idle write, flag a busy write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= SNOOP_NONE;
            err_q  <= 1'b0;
        end else if (cfg_valid) begin
            if (idle) mode_q <= snoop_mode_e'(cfg_mode);
            else      err_q  <= 1'b1;
        end
    end

    // The mode only changes after an idle write (R8).
    assert_mode_change_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != $past(mode_q)) |-> $past(cfg_valid && idle));

    // The error flag rises only after a busy write (R9).
    assert_err_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_q) |-> $past(cfg_valid && !idle));

    // The error flag is sticky until reset (R9).
    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);

endmodule

// File: rtl/snoop_router.sv
// Module: snoop_router (top)
// Routes a channel's stream through a primary cipher unit and lets the
// secondary hash unit tap either the cipher's input or its output.
// Assumes: the units' ready signals do not depend combinationally on valid.
module snoop_router
    import snoop_router_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int PEND_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_valid,
    input  logic [1:0]        cfg_mode,
    output logic [1:0]        cur_mode,
    output logic              cfg_err,
    input  logic              mem_valid,
    input  logic [DATA_W-1:0] mem_data,
    input  logic              mem_last,
    output logic              mem_ready,
    output logic              pin_valid,
    output logic [DATA_W-1:0] pin_data,
    output logic              pin_last,
    input  logic              pin_ready,
    input  logic              pout_valid,
    input  logic [DATA_W-1:0] pout_data,
    input  logic              pout_last,
    output logic              pout_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_last,
    input  logic              out_ready,
    output logic              sec_valid,
    output logic [DATA_W-1:0] sec_data,
    output logic              sec_last,
    input  logic              sec_ready
);

    snoop_mode_e       mode_q;
    logic              idle;
    logic              tap_in;
    logic              tap_out;
    logic              ib_valid, ob_valid;
    logic [DATA_W-1:0] ib_data, ob_data;
    logic              ib_last, ob_last;

    // Purpose: decode the stored mode; reserved falls back to no tap.
    always_comb begin
        tap_in  = (mode_q == SNOOP_IN);
        tap_out = (mode_q == SNOOP_OUT);
    end

    snoop_mode_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_valid (cfg_valid),
        .cfg_mode  (cfg_mode),
        .idle      (idle),
        .mode_q    (mode_q),
        .err_q     (cfg_err)
    );

    snoop_track #(.PEND_W(PEND_W)) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_fire  (mem_valid && mem_ready),
        .in_last  (mem_last),
        .out_fire (pout_valid && pout_ready),
        .out_last (pout_last),
        .idle     (idle)
    );

    // Input side: memory to the primary unit, optional tap to the hash unit.
    snoop_fork #(.DATA_W(DATA_W)) u_in_fork (
        .clk     (clk),
        .rst_n   (rst_n),
        .tap_en  (tap_in),
        .hold    (cfg_valid),
        .s_valid (mem_valid),
        .s_data  (mem_data),
        .s_last  (mem_last),
        .s_ready (mem_ready),
        .a_valid (pin_valid),
        .a_data  (pin_data),
        .a_last  (pin_last),
        .a_ready (pin_ready),
        .b_valid (ib_valid),
        .b_data  (ib_data),
        .b_last  (ib_last),
        .b_ready (sec_ready)
    );

    // Output side: primary unit to the output path, optional tap to the hash unit.
    snoop_fork #(.DATA_W(DATA_W)) u_out_fork (
        .clk     (clk),
        .rst_n   (rst_n),
        .tap_en  (tap_out),
        .hold    (cfg_valid),
        .s_valid (pout_valid),
        .s_data  (pout_data),
        .s_last  (pout_last),
        .s_ready (pout_ready),
        .a_valid (out_valid),
        .a_data  (out_data),
        .a_last  (out_last),
        .a_ready (out_ready),
        .b_valid (ob_valid),
        .b_data  (ob_data),
        .b_last  (ob_last),
        .b_ready (sec_ready)
    );

    // Purpose: select which tap, if any, drives the hash unit's stream.
    always_comb begin
        if (tap_in) begin
            sec_valid = ib_valid;
            sec_data  = ib_data;
            sec_last  = ib_last;
        end else if (tap_out) begin
            sec_valid = ob_valid;
            sec_data  = ob_data;
            sec_last  = ob_last;
        end else begin
            sec_valid = 1'b0;
            sec_data  = '0;
            sec_last  = 1'b0;
        end
    end

    // Purpose: expose the stored mode.
    always_comb cur_mode = mode_q;

    // Without a tap, the hash stream stays quiet (R2).
    assert_no_tap_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tap_in && !tap_out) |-> !sec_valid);

    // Input tap: a memory transfer coincides with a hash transfer of the same end flag (R4, R7).
    assert_in_tap_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tap_in && mem_valid && mem_ready) |-> (sec_valid && sec_ready && sec_last == mem_last));

    // Output tap: an output transfer coincides with output-path and hash transfers (R6).
    assert_out_tap_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tap_out && pout_valid && pout_ready) |-> (out_valid && out_ready && sec_valid && sec_ready));

    // A mode write cycle stalls every stream (R11).
    assert_cfg_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> (!mem_ready && !pout_ready && !sec_valid && !pin_valid && !out_valid));

endmodule

// File: tb/snoop_router_tb.sv
module snoop_router_tb;

    localparam int  CLK_PERIOD = 10;
    localparam int  DW         = 32;
    localparam int  WD_LIMIT   = 20000;
    localparam logic [DW-1:0] KEY = 32'hA5A5_0F0F;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_valid = 1'b0;
    logic [1:0]    cfg_mode = 2'b00;
    logic [1:0]    cur_mode;
    logic          cfg_err;
    logic          mem_valid = 1'b0;
    logic [DW-1:0] mem_data = '0;
    logic          mem_last = 1'b0;
    logic          mem_ready;
    logic          pin_valid;
    logic [DW-1:0] pin_data;
    logic          pin_last;
    logic          pin_ready = 1'b0;
    logic          pout_valid = 1'b0;
    logic [DW-1:0] pout_data = '0;
    logic          pout_last = 1'b0;
    logic          pout_ready;
    logic          out_valid;
    logic [DW-1:0] out_data;
    logic          out_last;
    logic          out_ready = 1'b0;
    logic          sec_valid;
    logic [DW-1:0] sec_data;
    logic          sec_last;
    logic          sec_ready = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    snoop_router #(.DATA_W(DW), .PEND_W(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_mode(cfg_mode),
        .cur_mode(cur_mode), .cfg_err(cfg_err),
        .mem_valid(mem_valid), .mem_data(mem_data), .mem_last(mem_last), .mem_ready(mem_ready),
        .pin_valid(pin_valid), .pin_data(pin_data), .pin_last(pin_last), .pin_ready(pin_ready),
        .pout_valid(pout_valid), .pout_data(pout_data), .pout_last(pout_last), .pout_ready(pout_ready),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last), .out_ready(out_ready),
        .sec_valid(sec_valid), .sec_data(sec_data), .sec_last(sec_last), .sec_ready(sec_ready)
    );

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    // Bench-side model state.
    logic [DW:0] src_q[$];
    logic [DW:0] pq[$];
    logic [DW:0] exp_pin[$];
    logic [DW:0] exp_out[$];
    logic [DW:0] exp_sec[$];
    logic [1:0]  m_exp = 2'b00;
    bit          err_exp = 0;
    bit          in_open_m = 0;
    bit          out_open_m = 0;
    int          pend_m = 0;
    bit          cfg_req = 0;
    logic [1:0]  cfg_req_val = 2'b00;
    bit          p_en = 1;
    bit          src_rand = 1;
    int          mem_cnt = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle driver, model and comparison.
    initial begin
        forever begin
            bit mf, pif, pof, of_, sf, idle_m;
            logic [DW:0] w;
            @(negedge clk);
            if (!rst_n) begin
                cfg_valid = 0; mem_valid = 0; pout_valid = 0;
                pin_ready = 0; out_ready = 0; sec_ready = 0;
                continue;
            end
            cfg_valid = cfg_req;
            cfg_mode  = cfg_req_val;
            cfg_req   = 0;
            mem_valid = (src_q.size() > 0) && (!src_rand || ($urandom % 4 != 0));
            w = (src_q.size() > 0) ? src_q[0] : '0;
            mem_data = w[DW-1:0];
            mem_last = w[DW];
            pout_valid = (pq.size() > 0) && p_en && ($urandom % 4 != 0);
            w = (pq.size() > 0) ? pq[0] : '0;
            pout_data = w[DW-1:0];
            pout_last = w[DW];
            pin_ready = ($urandom % 4 != 0);
            out_ready = ($urandom % 4 != 0);
            sec_ready = ($urandom % 4 != 0);
            #1;
            // Stored mode and error flag follow the model (R8, R9).
            chk(cur_mode == m_exp, "R8 cur_mode", cur_mode, m_exp);
            chk(cfg_err == err_exp, "R9 cfg_err", cfg_err, err_exp);
            if (cfg_valid) begin
                chk(!mem_ready && !pout_ready && !pin_valid && !out_valid && !sec_valid,
                    "R11 stall on write", {mem_ready, pout_ready, pin_valid, out_valid, sec_valid}, 0);
            end
            mf  = mem_valid && mem_ready;
            pif = pin_valid && pin_ready;
            pof = pout_valid && pout_ready;
            of_ = out_valid && out_ready;
            sf  = sec_valid && sec_ready;
            if (m_exp == 2'b01) begin
                chk(mf == pif && mf == sf, "R4 in-tap joint transfer", {mf, pif, sf}, {mf, mf, mf});
                if (!sec_ready || !pin_ready) chk(!mem_ready, "R4 held when a consumer stalls", mem_ready, 0);
                chk(pof == of_, "R2 output pass in tap-in", pof, of_);
            end else if (m_exp == 2'b10) begin
                chk(pof == of_ && pof == sf, "R6 out-tap joint transfer", {pof, of_, sf}, {pof, pof, pof});
                if (!sec_ready || !out_ready) chk(!pout_ready, "R6 output path held", pout_ready, 0);
                chk(mf == pif, "R2 input pass in tap-out", mf, pif);
            end else begin
                chk(!sec_valid, "R2 no tap quiet", sec_valid, 0);
                chk(mf == pif && pof == of_, "R2 pass-through", {mf, pif, pof, of_}, {mf, mf, pof, pof});
            end
            // Scoreboards: memory side.
            if (mf) begin
                w = src_q.pop_front();
                exp_pin.push_back(w);
                if (m_exp == 2'b01) exp_sec.push_back(w);
                mem_cnt++;
            end
            if (pif) begin
                w = (exp_pin.size() > 0) ? exp_pin.pop_front() : '1;
                chk({pin_last, pin_data} == w, "R3 primary input word", {pin_last, pin_data}, w);
                pq.push_back({pin_last, pin_data ^ KEY});
            end
            // Scoreboards: primary output side.
            if (pof) begin
                w = pq.pop_front();
                exp_out.push_back(w);
                if (m_exp == 2'b10) exp_sec.push_back(w);
            end
            if (of_) begin
                w = (exp_out.size() > 0) ? exp_out.pop_front() : '1;
                chk({out_last, out_data} == w, "R5 output path word", {out_last, out_data}, w);
            end
            if (sf) begin
                w = (exp_sec.size() > 0) ? exp_sec.pop_front() : '1;
                chk({sec_last, sec_data} == w, "R7 secondary word and end flag", {sec_last, sec_data}, w);
            end
            // Busy model and mode write decision (R10).
            idle_m = !in_open_m && !out_open_m && (pend_m == 0);
            if (cfg_valid) begin
                if (idle_m) m_exp = cfg_mode;
                else err_exp = 1;
            end
            if (mf) in_open_m = !mem_last;
            if (pof) out_open_m = !pout_last;
            if (mf && mem_last) pend_m++;
            if (pof && pout_last) pend_m--;
        end
    end

    task automatic send_pkt(input int n, input logic [DW-1:0] base);
        for (int i = 0; i < n; i++) src_q.push_back({(i == n - 1), base + DW'(i)});
    endtask

    task automatic write_mode(input logic [1:0] m);
        @(posedge clk); #1;
        cfg_req_val = m;
        cfg_req = 1;
        while (cfg_req) @(posedge clk);
        @(posedge clk);
    endtask

    task automatic drain();
        while (src_q.size() > 0 || pq.size() > 0 || exp_pin.size() > 0 ||
               exp_out.size() > 0 || exp_sec.size() > 0) @(posedge clk);
        repeat (2) @(posedge clk);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=running expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        int c0;
        rst_n = 0;
        repeat (4) @(posedge clk);
        #2 rst_n = 1;
        @(negedge clk); #2;
        chk(cur_mode == 2'b00, "R1 reset mode", cur_mode, 0);
        chk(cfg_err == 1'b0, "R1 reset error flag", cfg_err, 0);
        chk(sec_valid == 1'b0, "R1 reset secondary idle", sec_valid, 0);

        // Each mode with one packet (R2, R3, R5, R7, R8).
        write_mode(2'b00); send_pkt(4, 32'h1000); drain();
        write_mode(2'b01); send_pkt(5, 32'h2000); drain();
        write_mode(2'b10); send_pkt(6, 32'h3000); drain();
        write_mode(2'b11); send_pkt(3, 32'h4000); drain();
        chk(cur_mode == 2'b11, "R2 reserved mode stored", cur_mode, 3);
        write_mode(2'b01); send_pkt(1, 32'h5000); send_pkt(3, 32'h5100); drain();

        // Write during input (R9), then after input ends with output pending (R10).
        p_en = 0;
        send_pkt(6, 32'h6000);
        c0 = mem_cnt;
        while (mem_cnt < c0 + 2) @(posedge clk);
        write_mode(2'b10);
        chk(cur_mode == 2'b01, "R9 busy write ignored", cur_mode, 1);
        chk(cfg_err == 1'b1, "R9 busy write flagged", cfg_err, 1);
        while (src_q.size() > 0 || exp_sec.size() > 0) @(posedge clk);
        repeat (2) @(posedge clk);
        write_mode(2'b00);
        chk(cur_mode == 2'b01, "R10 output pending keeps busy", cur_mode, 1);
        p_en = 1;
        drain();
        write_mode(2'b10);
        chk(cur_mode == 2'b10, "R8 idle write accepted", cur_mode, 2);
        chk(cfg_err == 1'b1, "R9 error flag sticky", cfg_err, 1);

        // Mode write in the same cycle a word is offered (R11).
        src_rand = 0;
        @(posedge clk); #1;
        send_pkt(4, 32'h7000);
        cfg_req_val = 2'b01;
        cfg_req = 1;
        while (cfg_req) @(posedge clk);
        drain();
        chk(cur_mode == 2'b01, "R11 write taken alongside offered word", cur_mode, 1);
        src_rand = 1;
        send_pkt(7, 32'h8000); drain();

        chk(exp_sec.size() == 0 && exp_out.size() == 0 && exp_pin.size() == 0,
            "R3 no word missed or repeated", exp_sec.size(), 0);
        finished = 1;
        summary();
        $finish;
    end

endmodule